// File: doc/BRIEF.md
# Debug Port Transaction Sequencer

This block runs one debug-port transfer of up to eight bytes at a time for a requester. The requester gives a transfer kind (OUT, IN or SETUP), a device address, an endpoint, a byte count and a payload. The sequencer builds the packet-ID word, packs the payload into two 32-bit words, and pulses a start strobe towards the port. It then waits for the port to report completion, or for a timeout.

When the port reports completion, the sequencer acknowledges it with a one-cycle clear strobe. A NAK handshake or a bad-transfer error makes it reissue the same transfer, up to a bounded number of attempts. It ends every accepted or rejected request with a one-cycle `done` pulse and a signed `result`: a byte count when the transfer succeeds, or a negative error code. A timeout marks the port unsafe. The unsafe flag stays set, and refuses new requests, until the requester clears it.

Top module: `dbg_txn_seq`

## Requirements
- R1: A request with `req_len` above 8 is refused. `done` pulses in the next cycle with `result` = -1, no start strobe is issued, and the OUT data-PID state is left unchanged.
- R2: `port_len` equals `req_len`. Payload byte i is taken from `req_data[8i+7:8i]`. Bytes 0..3 go little-endian into `port_data_lo` and bytes 4..7 into `port_data_hi`. Byte lanes at or above `req_len` are driven as zero.
- R3: `port_pid` carries the token PID in bits 7:0 and the data PID in bits 15:8. The tokens are OUT 0xE1, IN 0x69 and SETUP 0x2D (`req_kind` 0, 1 and 2; the value 3 acts as SETUP). IN and SETUP always use DATA0 (0xC3), and `port_out` is 0 only for IN.
- R4: The data PID of OUT transfers starts at DATA0 (0xC3) after reset. It then flips between 0xC3 and 0x4B (XOR 0x88) once per accepted OUT request. It does not flip on a retry.
- R5: `port_go` is a one-cycle pulse for each attempt. `port_done_clr` is a one-cycle pulse in the cycle after each completion the port reports.
- R6: If no completion arrives within TIMEOUT_CYC cycles of the start strobe, the request ends with `result` = -2 and `unsafe` set, with no retry.
- R7: A completion with handshake PID NAK (0x5A) is reissued while fewer than MAX_TRIES attempts have been made. After the last attempt, `result` is the reported length.
- R8: Port error code 1 (bad transfer) is retried under the same attempt budget, and ends with -5 once the budget is used. Any other error code c ends the request at once with -(4+c).
- R9: A successful IN returns the received length in `result`. `rd_data` holds the first min(`req_len`, `port_rx_len`) received bytes, with the higher lanes zero.
- R10: While `unsafe` is set, a request of legal length ends with `result` = -3 and no start strobe. `unsafe` stays set until `clr_unsafe` is pulsed.
- R11: `busy` is high from acceptance until the `done` pulse. Requests presented while busy are ignored.
- R12: After reset, `busy`, `done`, `unsafe` and `port_go` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 2 | 0 OUT, 1 IN, 2 or 3 SETUP |
| req_addr | input | 7 | Device address |
| req_ep | input | 4 | Endpoint number |
| req_len | input | 4 | Byte count |
| req_data | input | 64 | Payload, byte i in bits 8i+7:8i |
| clr_unsafe | input | 1 | Clears the unsafe flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | RES_W | Signed length or error code |
| rd_data | output | 64 | Received bytes of the last successful IN |
| unsafe | output | 1 | Sticky timeout flag |
| port_go | output | 1 | Start strobe to the port |
| port_done_clr | output | 1 | Completion acknowledge to the port |
| port_out | output | 1 | Direction, 1 = host to device |
| port_len | output | 4 | Length field |
| port_pid | output | 16 | Data PID and token PID |
| port_addr | output | 7 | Device address |
| port_ep | output | 4 | Endpoint |
| port_data_lo | output | 32 | Payload bytes 0..3 |
| port_data_hi | output | 32 | Payload bytes 4..7 |
| port_done | input | 1 | Port completion flag |
| port_err | input | 1 | Port reports an error |
| port_err_code | input | 2 | Error kind, 1 = bad transfer |
| port_hs_pid | input | 8 | Handshake PID seen by the port |
| port_rx_len | input | 4 | Length reported by the port |
| port_rx_data | input | 64 | Received bytes |

## Verification
The bench targets several corner cases that a faulty design would get wrong in visible ways:
- NAK retries. A design that toggled the OUT data PID on each retry would send 0x4B where 0xC3 is due.
- The last NAK attempt. A design that got it wrong would report an error or make one start strobe too many, instead of returning the length.
- An IN where the port reports more or fewer bytes than were asked for. This exposes a design that did not clip `rd_data` to the smaller count.
- An oversize request placed just before an OUT. A design that advanced the toggle on rejection would emit the wrong PID on that OUT.
- A timeout, followed by a blocked request and then the clear. These show whether `unsafe` leaks, fails to block, or fails to release.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  typedef enum logic [1:0] {
    K_OUT   = 2'd0,
    K_IN    = 2'd1,
    K_SETUP = 2'd2
  } kind_e;

  localparam logic [7:0] TOK_OUT   = 8'hE1;
  localparam logic [7:0] TOK_IN    = 8'h69;
  localparam logic [7:0] TOK_SETUP = 8'h2D;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_FLIP  = 8'h88;
  localparam logic [7:0] PID_NAK   = 8'h5A;

  localparam logic [1:0] ERR_BAD   = 2'd1;

  localparam int RES_OVERSIZE  = -1;
  localparam int RES_TIMEOUT   = -2;
  localparam int RES_BLOCKED   = -3;
  localparam int RES_PORT_BASE = -4;
endpackage

// File: rtl/dbg_pid_gen.sv
module dbg_pid_gen
  import dbg_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [1:0]  kind,
  output logic [15:0] pid_word
);
  logic odd;

  // Toggle state advances once per accepted OUT request
  always_ff @(posedge clk) begin
    if (rst) odd <= 1'b0;
    else if (load && kind == K_OUT) odd <= ~odd;
  end

  always_comb begin
    case (kind)
      K_OUT:   pid_word = {PID_DATA0 ^ (odd ? PID_FLIP : 8'h00), TOK_OUT};
      K_IN:    pid_word = {PID_DATA0, TOK_IN};
      default: pid_word = {PID_DATA0, TOK_SETUP};
    endcase
  end
endmodule

// File: rtl/dbg_byte_mask.sv
module dbg_byte_mask #(
  parameter int NBYTES = 8,
  parameter int KW     = 4
) (
  input  logic [8*NBYTES-1:0] din,
  input  logic [KW-1:0]       keep,
  output logic [8*NBYTES-1:0] dout
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign dout[8*i +: 8] = (keep > KW'(i)) ? din[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/dbg_wait_timer.sv
module dbg_wait_timer #(
  parameter int LIMIT = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  // Masked during the start cycle so a stale count never fires
  assign expired = !restart && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dbg_txn_seq.sv
module dbg_txn_seq
  import dbg_seq_pkg::*;
#(
  parameter int NBYTES      = 8,
  parameter int TIMEOUT_CYC = 250000,
  parameter int MAX_TRIES   = 1000,
  parameter int RES_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [1:0]              req_kind,
  input  logic [6:0]              req_addr,
  input  logic [3:0]              req_ep,
  input  logic [3:0]              req_len,
  input  logic [63:0]             req_data,
  input  logic                    clr_unsafe,
  output logic                    busy,
  output logic                    done,
  output logic signed [RES_W-1:0] result,
  output logic [63:0]             rd_data,
  output logic                    unsafe,
  output logic                    port_go,
  output logic                    port_done_clr,
  output logic                    port_out,
  output logic [3:0]              port_len,
  output logic [15:0]             port_pid,
  output logic [6:0]              port_addr,
  output logic [3:0]              port_ep,
  output logic [31:0]             port_data_lo,
  output logic [31:0]             port_data_hi,
  input  logic                    port_done,
  input  logic                    port_err,
  input  logic [1:0]              port_err_code,
  input  logic [7:0]              port_hs_pid,
  input  logic [3:0]              port_rx_len,
  input  logic [63:0]             port_rx_data
);
  localparam int LOOP_W = $clog2(MAX_TRIES + 1);
  localparam logic [3:0] MAX_LEN = 4'(NBYTES);
  localparam logic signed [RES_W-1:0] R_OVR  = RES_W'(RES_OVERSIZE);
  localparam logic signed [RES_W-1:0] R_TMO  = RES_W'(RES_TIMEOUT);
  localparam logic signed [RES_W-1:0] R_BLK  = RES_W'(RES_BLOCKED);
  localparam logic signed [RES_W-1:0] R_PORT = RES_W'(RES_PORT_BASE);

  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e st;

  logic [1:0]        cur_kind;
  logic [3:0]        cur_len;
  logic [LOOP_W-1:0] loops;
  logic [15:0]       pid_next;
  logic [63:0]       tx_masked, rx_masked;
  logic [3:0]        rx_keep;
  logic              accept, tmo;

  assign accept  = (st == S_IDLE) && req_valid && (req_len <= MAX_LEN) && !unsafe;
  assign rx_keep = (port_rx_len < cur_len) ? port_rx_len : cur_len;

  dbg_pid_gen i_pid (
    .clk(clk), .rst(rst), .load(accept), .kind(req_kind), .pid_word(pid_next)
  );

  dbg_byte_mask #(.NBYTES(NBYTES), .KW(4)) i_txmask (
    .din(req_data), .keep(req_len), .dout(tx_masked)
  );

  dbg_byte_mask #(.NBYTES(NBYTES), .KW(4)) i_rxmask (
    .din(port_rx_data), .keep(rx_keep), .dout(rx_masked)
  );

  dbg_wait_timer #(.LIMIT(TIMEOUT_CYC)) i_tmr (
    .clk(clk), .rst(rst), .restart(port_go), .expired(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      busy          <= 1'b0;
      done          <= 1'b0;
      result        <= '0;
      rd_data       <= '0;
      unsafe        <= 1'b0;
      port_go       <= 1'b0;
      port_done_clr <= 1'b0;
      port_out      <= 1'b0;
      port_len      <= '0;
      port_pid      <= '0;
      port_addr     <= '0;
      port_ep       <= '0;
      port_data_lo  <= '0;
      port_data_hi  <= '0;
      cur_kind      <= '0;
      cur_len       <= '0;
      loops         <= '0;
    end else begin
      done          <= 1'b0;
      port_go       <= 1'b0;
      port_done_clr <= 1'b0;
      if (clr_unsafe) unsafe <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (req_len > MAX_LEN) begin
              done   <= 1'b1;
              result <= R_OVR;
            end else if (unsafe) begin
              done   <= 1'b1;
              result <= R_BLK;
            end else begin
              cur_kind     <= req_kind;
              cur_len      <= req_len;
              port_pid     <= pid_next;
              port_len     <= req_len;
              port_out     <= (req_kind != K_IN);
              port_addr    <= req_addr;
              port_ep      <= req_ep;
              port_data_lo <= tx_masked[31:0];
              port_data_hi <= tx_masked[63:32];
              loops        <= LOOP_W'(MAX_TRIES);
              port_go      <= 1'b1;
              busy         <= 1'b1;
              st           <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (port_done) begin
            port_done_clr <= 1'b1;
            if (port_err) begin
              if (port_err_code == ERR_BAD && loops > LOOP_W'(1)) begin
                loops   <= loops - 1'b1;
                port_go <= 1'b1;
              end else begin
                result <= R_PORT - RES_W'(port_err_code);
                done   <= 1'b1;
                busy   <= 1'b0;
                st     <= S_IDLE;
              end
            end else if (port_hs_pid == PID_NAK && loops > LOOP_W'(1)) begin
              loops   <= loops - 1'b1;
              port_go <= 1'b1;
            end else begin
              result <= RES_W'(port_rx_len);
              if (cur_kind == K_IN) rd_data <= rx_masked;
              done   <= 1'b1;
              busy   <= 1'b0;
              st     <= S_IDLE;
            end
          end else if (tmo) begin
            unsafe <= 1'b1;
            result <= R_TMO;
            done   <= 1'b1;
            busy   <= 1'b0;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_txn_seq_chk.sv
module dbg_txn_seq_chk #(
  parameter int NBYTES = 8,
  parameter int RES_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic [3:0]              req_len,
  input logic                    clr_unsafe,
  input logic                    busy,
  input logic                    done,
  input logic signed [RES_W-1:0] result,
  input logic                    unsafe,
  input logic                    port_go,
  input logic                    port_done_clr
);
  // R5
  go_single_chk: assert property (@(posedge clk) disable iff (rst)
    port_go |=> !port_go);

  // R5
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    port_done_clr |=> !port_done_clr);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    port_go |-> busy);

  // R10
  unsafe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (unsafe && !clr_unsafe) |=> unsafe);

  // R1
  oversize_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_len > 4'(NBYTES)) |=> (done && result == -1 && !port_go));

  // R10
  blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_len <= 4'(NBYTES) && unsafe) |=> (done && result == -3 && !port_go));
endmodule

bind dbg_txn_seq dbg_txn_seq_chk #(.NBYTES(NBYTES), .RES_W(RES_W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
  .clr_unsafe(clr_unsafe), .busy(busy), .done(done), .result(result),
  .unsafe(unsafe), .port_go(port_go), .port_done_clr(port_done_clr)
);

// File: tb/test_dbg_txn_seq.sv
`timescale 1ns/1ps
module test_dbg_txn_seq;
  localparam int NB = 8, TO = 20, TRIES = 3, RW = 16;

  typedef struct {
    int         dly;
    bit         err;
    int         code;
    logic [7:0] hs;
    int         rxlen;
    logic [63:0] rxd;
  } resp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, clr_unsafe = 0;
  logic [1:0]  req_kind = 0;
  logic [6:0]  req_addr = 7'd127;
  logic [3:0]  req_ep = 4'd1, req_len = 0;
  logic [63:0] req_data = 0;
  logic        port_done = 0, port_err = 0;
  logic [1:0]  port_err_code = 0;
  logic [7:0]  port_hs_pid = 0;
  logic [3:0]  port_rx_len = 0;
  logic [63:0] port_rx_data = 0;

  wire busy, done, unsafe, port_go, port_done_clr, port_out;
  wire signed [RW-1:0] result;
  wire [63:0] rd_data;
  wire [3:0]  port_len, port_ep;
  wire [15:0] port_pid;
  wire [6:0]  port_addr;
  wire [31:0] port_data_lo, port_data_hi;

  dbg_txn_seq #(.NBYTES(NB), .TIMEOUT_CYC(TO), .MAX_TRIES(TRIES), .RES_W(RW)) i_dbg_txn_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_ep(req_ep), .req_len(req_len), .req_data(req_data),
    .clr_unsafe(clr_unsafe), .busy(busy), .done(done), .result(result),
    .rd_data(rd_data), .unsafe(unsafe), .port_go(port_go),
    .port_done_clr(port_done_clr), .port_out(port_out), .port_len(port_len),
    .port_pid(port_pid), .port_addr(port_addr), .port_ep(port_ep),
    .port_data_lo(port_data_lo), .port_data_hi(port_data_hi),
    .port_done(port_done), .port_err(port_err), .port_err_code(port_err_code),
    .port_hs_pid(port_hs_pid), .port_rx_len(port_rx_len), .port_rx_data(port_rx_data)
  );

  int checks = 0, fails = 0, go_cnt = 0, clr_cnt = 0, cnt_dly = 0;
  bit odd_m = 0, unsafe_m = 0;
  logic [15:0] e_pid;
  logic [3:0]  e_len;
  logic        e_out;
  logic [63:0] e_data;
  resp_t rq[$];
  resp_t cur;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] bmask(logic [63:0] d, int n);
    for (int i = 0; i < 8; i++) if (i >= n) d[8*i +: 8] = 8'h00;
    return d;
  endfunction

  task automatic push(int dly, bit err, int code, logic [7:0] hs, int rxlen, logic [63:0] rxd);
    resp_t r;
    r.dly = dly; r.err = err; r.code = code; r.hs = hs; r.rxlen = rxlen; r.rxd = rxd;
    rq.push_back(r);
  endtask

  // Port model: answers each start strobe from the response queue
  initial begin
    forever begin
      @(negedge clk);
      if (port_done && port_done_clr) begin
        port_done = 0;
        clr_cnt++;
      end
      if (cnt_dly > 0) begin
        cnt_dly--;
        if (cnt_dly == 0) begin
          port_done = 1; port_err = cur.err; port_err_code = 2'(cur.code);
          port_hs_pid = cur.hs; port_rx_len = 4'(cur.rxlen); port_rx_data = cur.rxd;
        end
      end
      if (port_go) begin
        go_cnt++;
        chk(port_pid == e_pid, "R3 R4 pid word", port_pid, e_pid);
        chk(port_len == e_len, "R2 length field", port_len, e_len);
        chk(port_out == e_out, "R3 direction", port_out, e_out);
        chk({port_data_hi, port_data_lo} == e_data, "R2 payload packing",
            {port_data_hi, port_data_lo}, e_data);
        if (rq.size() > 0) begin
          cur = rq.pop_front();
          cnt_dly = cur.dly;
        end else cnt_dly = 0;
      end
    end
  end

  task automatic run(logic [1:0] kind, logic [3:0] len, logic [63:0] d, bit poke, string tag);
    int e_res, e_go, e_clr, g0, c0, n, k;
    logic [63:0] e_rd;
    resp_t r;
    e_go = 0; e_clr = 0; e_rd = 0; e_res = 0;
    if (len > 4'(NB)) e_res = -1;
    else if (unsafe_m) e_res = -3;
    else begin
      e_len = len; e_out = (kind != 2'd1); e_data = bmask(d, int'(len));
      case (kind)
        2'd0:    e_pid = {odd_m ? 8'h4B : 8'hC3, 8'hE1};
        2'd1:    e_pid = {8'hC3, 8'h69};
        default: e_pid = {8'hC3, 8'h2D};
      endcase
      if (kind == 2'd0) odd_m = ~odd_m;
      for (int a = 1; a <= TRIES; a++) begin
        r = rq[a-1];
        e_go = a;
        if (r.dly == 0) begin e_res = -2; unsafe_m = 1; break; end
        e_clr++;
        if (r.err) begin
          if (r.code == 1 && a < TRIES) continue;
          e_res = -(4 + r.code);
          break;
        end
        if (r.hs == 8'h5A && a < TRIES) continue;
        e_res = r.rxlen;
        k = (r.rxlen < int'(len)) ? r.rxlen : int'(len);
        e_rd = bmask(r.rxd, k);
        break;
      end
    end
    g0 = go_cnt; c0 = clr_cnt;
    @(negedge clk);
    req_kind = kind; req_len = len; req_data = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      chk(busy == 1'b1, "R11 busy during transfer", busy, 1);
      req_kind = 2'd0; req_len = 4'd3; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
    end
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    #1;
    chk(done == 1'b1, {tag, " done pulse"}, done, 1);
    chk(busy == 1'b0, "R11 busy low at done", busy, 0);
    chk(int'(result) == e_res, {tag, " result"}, result, e_res);
    chk(go_cnt - g0 == e_go, "R7 start strobe count", go_cnt - g0, e_go);
    chk(clr_cnt - c0 == e_clr, "R5 completion clear count", clr_cnt - c0, e_clr);
    chk(unsafe == unsafe_m, "R6 unsafe flag", unsafe, unsafe_m);
    if (kind == 2'd1 && e_res >= 0)
      chk(rd_data == e_rd, "R9 read data", rd_data, e_rd);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R5 done is one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(busy == 0, "R12 busy", busy, 0);
    chk(done == 0, "R12 done", done, 0);
    chk(unsafe == 0, "R12 unsafe", unsafe, 0);
    chk(port_go == 0, "R12 port_go", port_go, 0);

    push(2, 0, 0, 8'hD2, 5, 0);
    run(2'd0, 4'd5, 64'h8877665544332211, 0, "R2");
    push(1, 0, 0, 8'hD2, 8, 0);
    run(2'd0, 4'd8, 64'h0123456789ABCDEF, 0, "R4");
    push(1, 0, 0, 8'h5A, 3, 0); push(2, 0, 0, 8'h5A, 3, 0); push(1, 0, 0, 8'hD2, 3, 0);
    run(2'd0, 4'd3, 64'hFFFF_FFFF_FFAA_BBCC, 0, "R7");
    push(1, 0, 0, 8'h5A, 2, 0); push(1, 0, 0, 8'h5A, 2, 0); push(1, 0, 0, 8'h5A, 2, 0);
    run(2'd0, 4'd2, 64'h1111, 0, "R7");
    push(3, 0, 0, 8'hC3, 4, 64'hA8A7A6A5A4A3A2A1);
    run(2'd1, 4'd6, 0, 0, "R9");
    push(1, 0, 0, 8'h4B, 7, 64'hB8B7B6B5B4B3B2B1);
    run(2'd1, 4'd2, 0, 0, "R9");
    push(1, 0, 0, 8'hD2, 8, 0);
    run(2'd2, 4'd8, 64'h0000_0008_0000_0680, 0, "R3");
    push(1, 1, 1, 8'h00, 0, 0); push(1, 0, 0, 8'hD2, 1, 0);
    run(2'd0, 4'd1, 64'h20, 0, "R8");
    push(1, 1, 1, 8'h00, 0, 0); push(1, 1, 1, 8'h00, 0, 0); push(1, 1, 1, 8'h00, 0, 0);
    run(2'd1, 4'd8, 0, 0, "R8");
    push(1, 1, 2, 8'h00, 0, 0);
    run(2'd1, 4'd8, 0, 0, "R8");
    run(2'd0, 4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R1");
    push(1, 0, 0, 8'hD2, 1, 0);
    run(2'd0, 4'd1, 64'h41, 0, "R1");
    push(6, 0, 0, 8'hC3, 4, 64'h44332211);
    run(2'd1, 4'd4, 0, 1, "R11");
    push(0, 0, 0, 8'h00, 0, 0);
    run(2'd0, 4'd1, 64'h5A, 0, "R6");
    run(2'd1, 4'd2, 0, 0, "R10");
    @(negedge clk);
    clr_unsafe = 1;
    @(negedge clk);
    clr_unsafe = 0;
    unsafe_m = 0;
    #1;
    chk(unsafe == 0, "R10 clear releases unsafe", unsafe, 0);
    push(1, 0, 0, 8'hD2, 2, 0);
    run(2'd0, 4'd2, 64'h7766, 0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule